// File: doc/BRIEF.md
# Serial-Output Sampling Converter Digital Model

This block models the digital side of a 12-bit differential sampling converter with a three-wire serial port. An external host drives an active-low select line and a serial clock. The block answers on one data line, which it either drives or releases. A fast system clock oversamples both host lines through two-flop synchronizers and detects their edges. The block counts the falling serial-clock edges that follow each falling select.

The result word is two's complement and comes in on a parallel test port with a valid/ready handshake. The port never applies back-pressure. `smp_ready` stays high whenever the block is out of reset. Each accepted word replaces the staged value, and the newest one wins. The staged word is frozen into the output register at the second falling serial edge of a frame.

On the serial line the block first drives a zero null bit, then the word MSB first. If select stays low, it replays the word LSB first without repeating B0, and then releases the line. The block also reports two power-down levels. The digital level is down whenever no frame is live. The analog level goes down at that time and also late in a long frame.

Top module: `serial_adc_model`

## Requirements
- R1: After reset with select high, `dout_en` is 0, `digital_off` and `analog_off` are 1, and `smp_ready` is 1.
- R2: At the first falling serial edge after select falls, the line stays released (`dout_en`=0). At the second edge `dout_en` becomes 1 and `dout` carries the null bit, value 0.
- R3: Falling edges 3 to 14 put result bits B11 down to B0 on `dout`, one bit per edge. Edge k carries bit 14-k.
- R4: While select stays low, edges 15 to 25 carry B1 up to B11, so edge k carries bit k-14. From edge 26 on the line is released, and further edges change nothing.
- R5: A rise of select releases the line and raises `digital_off` within 3 system clocks. A frame cut short this way is never replayed.
- R6: The word is frozen at the second falling edge. Words accepted later in the frame do not change the bits of that frame.
- R7: A frame starts only on a high-to-low transition of select that is seen after reset. Select held low through reset, or serial edges while select is high, never drive the line.
- R8: `analog_off` rises at falling edge 16 while select stays low, and `digital_off` stays 0 until select rises. Whenever `digital_off` is 1, `analog_off` is 1 too.
- R9: Codes pass unchanged in two's complement. 7FF (positive full scale), 000, FFF (one step below zero) and 800 (negative full scale) are each shifted out bit for bit.
- R10: `smp_data` is accepted in a cycle when both `smp_valid` and `smp_ready` are 1. The last word accepted before a frame's second edge is the word that frame sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_in | input | 1 | Active-low select from the host, asynchronous |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| smp_data | input | 12 | Two's-complement word offered on the test port |
| smp_valid | input | 1 | `smp_data` is valid |
| smp_ready | output | 1 | Test port can accept a word (high whenever out of reset) |
| dout | output | 1 | Serial data bit, 0 while released |
| dout_en | output | 1 | 1 while the block drives the data line |
| analog_off | output | 1 | Analog section powered down |
| digital_off | output | 1 | Full power-down, no frame live |

## Verification
The bench goes after the boundaries of the frame. It checks the quiet first edge, the zero null bit, the B0 turnaround where the replay must start at B1 and not repeat B0, and the release after B11. A design that is off by one edge would shift every bit or drive the line one edge early or late. A design that replays B0 would put the whole replay one position late. The bench also raises select mid-word and then pulses the serial clock; a design that missed the rise would keep driving or resume the frame. It offers a new word mid-frame, which catches a design that reads the port live instead of freezing the word. Finally it holds select low through reset, which catches a design that starts a frame from reset values.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  // Falling-edge numbers (1-based after select falls) of the frame landmarks
  function automatic int null_edge();
    return 2;
  endfunction
  function automatic int first_bit_edge();
    return 3;
  endfunction
  function automatic int last_fwd_edge(input int w);
    return first_bit_edge() + w - 1;
  endfunction
  function automatic int last_replay_edge(input int w);
    return last_fwd_edge(w) + w - 1;
  endfunction
endpackage

// File: rtl/adcm_sync.sv
module adcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/adcm_frame.sv
module adcm_frame #(
  parameter int CNT_W = 5,
  parameter int STOP  = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fall,
  input  logic             sel_rise,
  input  logic             sck_fall,
  output logic             live,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] STOP_C = CNT_W'(STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0;
      cnt  <= '0;
    end else if (sel_rise) begin
      live <= 1'b0;
      cnt  <= '0;
    end else if (sel_fall) begin
      live <= 1'b1;
      cnt  <= '0;
    end else if (live && sck_fall && cnt < STOP_C) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcm_shifter.sv
module adcm_shifter
  import adcm_pkg::*;
#(
  parameter int W     = 12,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             sck_fall,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     staged,
  output logic             dout,
  output logic             dout_en
);
  localparam logic [CNT_W-1:0] NULL_C = CNT_W'(null_edge());
  localparam logic [CNT_W-1:0] FRST_C = CNT_W'(first_bit_edge());
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(last_fwd_edge(W));
  localparam logic [CNT_W-1:0] END_C  = CNT_W'(last_replay_edge(W));
  localparam logic [CNT_W-1:0] LOAD_C = NULL_C - 1'b1;

  logic [W-1:0]     word;
  logic [CNT_W-1:0] idx;
  logic [W-1:0]     shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else if (live && sck_fall && cnt == LOAD_C) word <= staged;
  end

  always_comb begin
    idx = '0;
    if (cnt >= FRST_C && cnt <= LAST_C) idx = LAST_C - cnt;
    else if (cnt > LAST_C && cnt <= END_C) idx = cnt - LAST_C;
    shifted = word >> idx;
    dout_en = live && cnt >= NULL_C && cnt <= END_C;
    dout    = dout_en && cnt >= FRST_C && shifted[0];
  end
endmodule

// File: rtl/serial_adc_model.sv
module serial_adc_model
  import adcm_pkg::*;
#(
  parameter int W       = 12,
  parameter int SYNC    = 2,
  parameter int PD_EDGE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n_in,
  input  logic         sclk_in,
  input  logic [W-1:0] smp_data,
  input  logic         smp_valid,
  output logic         smp_ready,
  output logic         dout,
  output logic         dout_en,
  output logic         analog_off,
  output logic         digital_off
);
  localparam int STOP  = last_replay_edge(W) + 1;
  localparam int CNT_W = $clog2(STOP + 1);
  localparam logic [CNT_W-1:0] PD_C = CNT_W'(PD_EDGE);

  logic sel_rise, sel_fall, sck_rise, sck_fall;
  logic live;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0] staged;

  // select is active low: its falling edge opens a frame
  adcm_sync #(.STAGES(SYNC)) u_sel (
    .clk(clk), .rst_n(rst_n), .d(cs_n_in), .rise(sel_rise), .fall(sel_fall));
  adcm_sync #(.STAGES(SYNC)) u_sck (
    .clk(clk), .rst_n(rst_n), .d(sclk_in), .rise(sck_rise), .fall(sck_fall));

  adcm_frame #(.CNT_W(CNT_W), .STOP(STOP)) u_frame (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sck_fall(sck_fall), .live(live), .cnt(cnt));

  adcm_shifter #(.W(W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .live(live), .sck_fall(sck_fall), .cnt(cnt),
    .staged(staged), .dout(dout), .dout_en(dout_en));

  // test port: never back-pressures, newest accepted word wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_ready <= 1'b0;
      staged    <= '0;
    end else begin
      smp_ready <= 1'b1;
      if (smp_valid && smp_ready) staged <= smp_data;
    end
  end

  assign digital_off = !live;
  assign analog_off  = !live || cnt >= PD_C;

  logic unused_rise;
  assign unused_rise = sck_rise;
endmodule

// File: rtl/adcm_chk.sv
module adcm_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_in,
  input logic dout,
  input logic dout_en,
  input logic analog_off,
  input logic digital_off
);
  // R2
  null_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> !dout);

  // R5
  release_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n_in, 1) && $past(cs_n_in, 2) && $past(cs_n_in, 3)) |-> (!dout_en && digital_off));

  // R8
  power_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digital_off |-> analog_off);

  // R4
  late_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dout_en) && !digital_off) |-> analog_off);

  // R7
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> (!analog_off && !digital_off));
endmodule

bind serial_adc_model adcm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .dout(dout), .dout_en(dout_en),
  .analog_off(analog_off), .digital_off(digital_off));

// File: tb/serial_adc_model_test.sv
module serial_adc_model_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_in = 1'b1;
  logic sclk_in = 1'b0;
  logic [11:0] smp_data = '0;
  logic smp_valid = 1'b0;
  logic smp_ready, dout, dout_en, analog_off, digital_off;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  serial_adc_model uut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .dout(dout), .dout_en(dout_en), .analog_off(analog_off),
    .digital_off(digital_off));

  // R9: full scale, zero, one step below zero, negative full scale, mixed
  localparam logic [11:0] VEC [6] = '{12'h7FF, 12'h000, 12'hFFF, 12'h800, 12'hA5C, 12'h3E1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [11:0] w);
    @(negedge clk); smp_data = w; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  // one serial period: rise, fall, then settle before sampling
  task automatic pulse();
    sclk_in = 1'b1; waitn(8);
    sclk_in = 1'b0; waitn(6);
  endtask

  task automatic sel(input logic v);
    @(negedge clk); cs_n_in = v; waitn(8);
  endtask

  // expected line state after falling edge k with select held low
  function automatic logic [1:0] expect_line(input int k, input logic [11:0] w);
    if (k < 2 || k > 25) return 2'b00;
    if (k == 2)          return 2'b10;
    if (k <= 14)         return {1'b1, w[14-k]};
    return {1'b1, w[k-14]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitn(4); rst_n = 1'b1; waitn(6);
    // R1 reset state
    chk(!dout_en && digital_off && analog_off && smp_ready, "R1 reset",
        {dout_en, digital_off, analog_off, smp_ready}, 4'b0111);

    // vector table: full double frames, R2 R3 R4 R8 R9 R10
    foreach (VEC[i]) begin
      push(VEC[i]);
      sel(1'b0);
      for (int k = 1; k <= 28; k++) begin
        logic [1:0] e;
        pulse();
        e = expect_line(k, VEC[i]);
        chk({dout_en, dout} == e, "R3/R4 frame bit", {dout_en, dout}, e);
        chk(analog_off == (k >= 16), "R8 analog level", analog_off, k >= 16);
        chk(!digital_off, "R8 digital stays on", digital_off, 0);
      end
      sel(1'b1);
      chk(digital_off && !dout_en, "R5 end of frame", {digital_off, dout_en}, 2'b10);
    end

    // R2 first edge quiet, second edge null
    push(12'hFFF);
    sel(1'b0);
    pulse();
    chk(!dout_en, "R2 first edge released", dout_en, 0);
    pulse();
    chk(dout_en && !dout, "R2 null bit", {dout_en, dout}, 2'b10);

    // R6 word offered mid-frame is ignored by this frame
    push(12'h000);
    for (int k = 3; k <= 14; k++) begin
      pulse();
      chk(dout_en && dout, "R6 frozen word", {dout_en, dout}, 2'b11);
    end
    sel(1'b1);
    // R10 next frame sends the newest accepted word (000)
    sel(1'b0);
    for (int k = 1; k <= 14; k++) pulse();
    chk(dout_en && !dout, "R10 newest word B0", {dout_en, dout}, 2'b10);
    sel(1'b1);

    // R5 short cycle: select rises mid-word, no replay afterwards
    push(12'h9C3);
    sel(1'b0);
    for (int k = 1; k <= 8; k++) pulse();
    chk(dout_en && dout == 1'b1, "R5 bit before cut", dout, 1);
    @(negedge clk); cs_n_in = 1'b1; waitn(3);
    chk(!dout_en && digital_off, "R5 release in 3 clocks", {dout_en, digital_off}, 2'b01);
    for (int k = 1; k <= 20; k++) begin
      pulse();
      chk(!dout_en, "R7 edges with select high", dout_en, 0);
    end

    // R4 edges beyond the frame have no effect
    sel(1'b0);
    for (int k = 1; k <= 40; k++) pulse();
    chk(!dout_en && analog_off && !digital_off, "R4 extra edges",
        {dout_en, analog_off, digital_off}, 3'b010);
    sel(1'b1);

    // R7 select held low through reset starts no frame
    @(negedge clk); rst_n = 1'b0; cs_n_in = 1'b0; waitn(4);
    rst_n = 1'b1; waitn(6);
    for (int k = 1; k <= 4; k++) begin
      pulse();
      chk(!dout_en && digital_off, "R7 no frame without high", {dout_en, digital_off}, 2'b01);
    end
    sel(1'b1);
    push(12'h800);
    sel(1'b0);
    pulse(); pulse(); pulse();
    chk(dout_en && dout, "R7 frame after high-low", {dout_en, dout}, 2'b11);
    sel(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule